// File: doc/BRIEF.md
# GPIO controller with interrupt unit

A register-mapped general-purpose pin controller for up to 32 pins, reached over a 32-bit APB bus with zero wait states. Every pin can be handed to an alternate-function path or kept under register control; under register control it has a direction, a drive enable and an output value, and its input is brought in through a two-stage synchronizer and can be read back. Pads are modelled as separate input, output and output-enable vectors.

Each pin also feeds an interrupt unit. A pin can sense a level (high or low) or an edge (rising, falling or both). Detected events latch into a status register that software reads; the read returns the latched bits and clears them all in the same access, so there is no separate acknowledge. A mask decides which latched bits reach the single registered host interrupt line; the mask is read-only and is changed through two write-one strobe registers, one that unmasks and one that masks. There is no data stream through the block: the bus is a control path, `pready` is always high, and no access is ever held off.

Register offsets (byte addresses, 32-bit words): 0x00 alternate select, 0x04 direction, 0x08 drive enable, 0x0C output value, 0x10 synchronized input (read-only), 0x14 mask (read-only), 0x18 unmask strobe, 0x1C mask strobe, 0x20 status (read clears), 0x24 sense kind, 0x28 polarity, 0x2C both-edge select.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every pin is an input (direction register reads all ones over the pin bits), every interrupt is masked (mask register reads all ones), status reads zero, `irq` is 0 and no pad is driven (`pin_oe` all zero).
- R2: The alternate select (0x00), direction (0x04), drive enable (0x08), output value (0x0C), sense kind (0x24), polarity (0x28) and both-edge (0x2C) registers read back the last value written over bits [NPINS-1:0]; bits at and above NPINS read as zero in every register.
- R3: For a pin whose alternate-select bit is 0, `pin_out` equals its output-value bit and `pin_oe` is 1 only when its direction bit is 0 (output) and its drive-enable bit is 1; for a pin whose alternate-select bit is 1, `pin_out` and `pin_oe` follow `alt_out` and `alt_oe`.
- R4: A read of 0x10 returns `pin_in` as it was two clock edges earlier; writes to 0x10 have no effect.
- R5: Writing 1 to a bit of 0x18 clears that mask bit, writing 1 to a bit of 0x1C sets it, zero bits in either write leave the mask unchanged, 0x14 reads the mask (1 = masked) and writes to 0x14 have no effect.
- R6: A pin whose sense-kind bit is 1 senses a level: polarity bit 1 sets its status bit while the synchronized input is high, polarity bit 0 while it is low.
- R7: A pin whose sense-kind bit is 0 senses an edge of the synchronized input: with both-edge bit 1 any change sets its status bit; otherwise polarity bit 1 selects rising edges and polarity bit 0 falling edges.
- R8: Status bits stay set until a read of 0x20, which returns the latched bits and clears all of them; an event present in the read cycle (such as a level still active) sets its bit again right after the read.
- R9: Status bits latch whatever the mask; `irq` is 1 one clock after some status bit is set while its mask bit is 0, and 0 one clock after no such bit exists.
- R10: `pready` is always 1; a read of an unmapped offset returns zero and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1, no wait states |
| pin_in | input | NPINS | Pad input values |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function output enables |
| irq | output | 1 | Combined, registered host interrupt |

## Verification
The sharpest corner is a status read while a level source stays active: a design that lets the clear win over the new event loses the interrupt, and one that never clears keeps stale edge bits, so the bench reads status twice in a row and expects only the still-active level bits the second time. Random mixes of sense kind, polarity and both-edge settings against random input transitions catch swapped polarity, a missing edge direction or edges detected before synchronization. Reads with a pin count below 32 catch registers that leak bits above the pin count, and strobe writes with zero bits catch a mask that is overwritten instead of set or cleared bit by bit.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  // Word offsets that software decodes.
  localparam logic [ADDR_W-1:0] OFS_ALT     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DRVEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_UNMASK  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_SETMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_KIND    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_POL     = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_BOTH    = 8'h2C;

  // One pin's trigger decision from its current and previous synchronized value.
  function automatic logic pin_event(input logic cur, input logic prev,
                                     input logic kind, input logic pol,
                                     input logic both);
    if (kind)      return cur == pol;
    else if (both) return cur ^ prev;
    else if (pol)  return cur & ~prev;
    else           return ~cur & prev;
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] din_s
);
  logic [NPINS-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign din_s = stg[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  input  logic [NPINS-1:0]  din_s,
  input  logic [NPINS-1:0]  stat_q,
  output logic [BUS_W-1:0]  prdata,
  output logic [NPINS-1:0]  alt_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  drven_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  kind_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  both_q,
  output logic              stat_rd
);
  logic             acc, wr;
  logic [NPINS-1:0] wd, rsel;

  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign stat_rd = acc & ~pwrite & (paddr == OFS_STAT);
  assign wd      = pwdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q   <= '0;
      dir_q   <= '1;
      drven_q <= '0;
      dout_q  <= '0;
      mask_q  <= '1;
      kind_q  <= '0;
      pol_q   <= '0;
      both_q  <= '0;
    end else if (wr) begin
      case (paddr)
        OFS_ALT:     alt_q   <= wd;
        OFS_DIR:     dir_q   <= wd;
        OFS_DRVEN:   drven_q <= wd;
        OFS_DOUT:    dout_q  <= wd;
        OFS_UNMASK:  mask_q  <= mask_q & ~wd;
        OFS_SETMASK: mask_q  <= mask_q | wd;
        OFS_KIND:    kind_q  <= wd;
        OFS_POL:     pol_q   <= wd;
        OFS_BOTH:    both_q  <= wd;
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (paddr)
      OFS_ALT:   rsel = alt_q;
      OFS_DIR:   rsel = dir_q;
      OFS_DRVEN: rsel = drven_q;
      OFS_DOUT:  rsel = dout_q;
      OFS_DIN:   rsel = din_s;
      OFS_MASK:  rsel = mask_q;
      OFS_STAT:  rsel = stat_q;
      OFS_KIND:  rsel = kind_q;
      OFS_POL:   rsel = pol_q;
      OFS_BOTH:  rsel = both_q;
      default:   rsel = '0;
    endcase
    prdata             = '0;
    prdata[NPINS-1:0]  = rsel;
  end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din_s,
  input  logic [NPINS-1:0] kind_q,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] both_q,
  input  logic [NPINS-1:0] mask_q,
  input  logic             stat_rd,
  output logic [NPINS-1:0] stat_q,
  output logic [NPINS-1:0] evt_v,
  output logic             irq
);
  logic [NPINS-1:0] prev_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_evt
    assign evt_v[p] = pin_event(din_s[p], prev_q[p], kind_q[p], pol_q[p], both_q[p]);
  end

  // A new event wins over the read clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= din_s;
      stat_q <= (stat_rd ? '0 : stat_q) | evt_v;
      irq    <= |(stat_q & ~mask_q);
    end
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic              irq
);
  logic [NPINS-1:0] din_s, alt_q, dir_q, drven_q, dout_q;
  logic [NPINS-1:0] mask_q, kind_q, pol_q, both_q, stat_q, evt_v;
  logic             stat_rd;

  assign pready = 1'b1;

  pinbank_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .din_s(din_s)
  );

  pinbank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .din_s(din_s), .stat_q(stat_q), .prdata(prdata),
    .alt_q(alt_q), .dir_q(dir_q), .drven_q(drven_q), .dout_q(dout_q),
    .mask_q(mask_q), .kind_q(kind_q), .pol_q(pol_q), .both_q(both_q),
    .stat_rd(stat_rd)
  );

  pinbank_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .din_s(din_s), .kind_q(kind_q),
    .pol_q(pol_q), .both_q(both_q), .mask_q(mask_q), .stat_rd(stat_rd),
    .stat_q(stat_q), .evt_v(evt_v), .irq(irq)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pin_out[p] = alt_q[p] ? alt_out[p] : dout_q[p];
    assign pin_oe[p]  = alt_q[p] ? alt_oe[p]  : (~dir_q[p] & drven_q[p]);
  end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]  pwdata,
  input logic              irq,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  evt_v,
  input logic              stat_rd
);
  logic wr_unmask, wr_setmask;
  assign wr_unmask  = psel & penable & pwrite & (paddr == OFS_UNMASK);
  assign wr_setmask = psel & penable & pwrite & (paddr == OFS_SETMASK);

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask_q & $past(pwdata[NPINS-1:0])) == '0)); // R5
  AST_SETMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setmask |=> ((mask_q & $past(pwdata[NPINS-1:0])) == $past(pwdata[NPINS-1:0]))); // R5
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_v == '0) |=> (stat_q == '0)); // R8
  AST_NEW_BIT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_v)) == '0)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&mask_q) |-> !irq); // R9
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .irq(irq), .mask_q(mask_q),
  .stat_q(stat_q), .evt_v(evt_v), .stat_rd(stat_rd)
);

// File: tb/test_pinbank_ctrl.sv
module test_pinbank_ctrl;
  localparam int NP = 20;
  localparam logic [NP-1:0] PM = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, irq;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pinbank_ctrl #(.NPINS(NP)) i_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [NP-1:0] lvl_hit(input logic [NP-1:0] v, input logic [NP-1:0] pol);
    return (v & pol) | (~v & ~pol);
  endfunction

  function automatic logic [NP-1:0] edge_hit(input logic [NP-1:0] a, input logic [NP-1:0] b,
                                             input logic [NP-1:0] pol, input logic [NP-1:0] both);
    logic [NP-1:0] rise, fall;
    rise = b & ~a;
    fall = a & ~b;
    return (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
  endfunction

  function automatic logic [NP-1:0] pad_out(input logic [NP-1:0] alt, input logic [NP-1:0] dout,
                                            input logic [NP-1:0] ao);
    return (alt & ao) | (~alt & dout);
  endfunction

  function automatic logic [NP-1:0] pad_oe(input logic [NP-1:0] alt, input logic [NP-1:0] dir,
                                           input logic [NP-1:0] drv, input logic [NP-1:0] aoe);
    return (alt & aoe) | (~alt & ~dir & drv);
  endfunction

  initial begin
    logic [31:0] rd, w;
    logic [NP-1:0] a, dr, dv, dt, m, kd, pl, bo, v0, v1, ex;
    logic [7:0] rw_ofs [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h24, 8'h28, 8'h2C};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 ready
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe", 32'(pin_oe), 32'd0);
    chk("R10 pready", {31'd0, pready}, 32'd1);
    apb_rd(8'h04, rd); chk("R1 direction", rd, 32'(PM));
    apb_rd(8'h14, rd); chk("R1 mask", rd, 32'(PM));
    apb_rd(8'h20, rd); chk("R1 status", rd, 32'd0);

    // R2 readback, upper bits zero
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 7; k++) begin
        w = $urandom();
        apb_wr(rw_ofs[k], w);
        apb_rd(rw_ofs[k], rd);
        chk("R2 readback", rd, w & 32'(PM));
      end
    end

    // R10 unmapped offset
    apb_wr(8'h08, 32'h0001_2345);
    apb_wr(8'h30, 32'hFFFF_FFFF);
    apb_rd(8'h30, rd); chk("R10 unmapped read", rd, 32'd0);
    apb_rd(8'h08, rd); chk("R10 unmapped write ignored", rd, 32'h0001_2345 & 32'(PM));

    // R3 pad muxing
    for (int i = 0; i < 10; i++) begin
      a = NP'($urandom()); dr = NP'($urandom()); dv = NP'($urandom()); dt = NP'($urandom());
      if (i == 0) a = '0;
      if (i == 1) a = PM;
      apb_wr(8'h00, 32'(a)); apb_wr(8'h04, 32'(dr));
      apb_wr(8'h08, 32'(dv)); apb_wr(8'h0C, 32'(dt));
      alt_out = NP'($urandom()); alt_oe = NP'($urandom());
      #1;
      chk("R3 pin_out", 32'(pin_out), 32'(pad_out(a, dt, alt_out)));
      chk("R3 pin_oe", 32'(pin_oe), 32'(pad_oe(a, dr, dv, alt_oe)));
    end

    // R4 synchronized input, write ignored
    for (int i = 0; i < 4; i++) begin
      v0 = NP'($urandom());
      pin_in = v0;
      apb_rd(8'h10, rd); chk("R4 input value", rd, 32'(v0));
      apb_wr(8'h10, $urandom());
      apb_rd(8'h10, rd); chk("R4 write ignored", rd, 32'(v0));
    end

    // R5 mask strobes
    apb_wr(8'h1C, 32'hFFFF_FFFF);
    m = NP'($urandom());
    apb_wr(8'h18, 32'(m));
    apb_rd(8'h14, rd); chk("R5 unmask", rd, 32'(PM & ~m));
    v0 = NP'($urandom());
    apb_wr(8'h1C, 32'(v0));
    apb_rd(8'h14, rd); chk("R5 setmask", rd, 32'((PM & ~m) | v0));
    apb_wr(8'h14, 32'd0);
    apb_wr(8'h18, 32'd0);
    apb_wr(8'h1C, 32'd0);
    apb_rd(8'h14, rd); chk("R5 zero writes ignored", rd, 32'((PM & ~m) | v0));

    // R6 R7 R8 R9 random sense configurations
    for (int i = 0; i < 24; i++) begin
      kd = NP'($urandom()); pl = NP'($urandom()); bo = NP'($urandom()); m = NP'($urandom());
      if (i == 0) begin kd = '0; bo = '0; pl = PM; end
      if (i == 1) begin kd = '0; bo = '0; pl = '0; end
      if (i == 2) begin kd = '0; bo = PM; end
      if (i == 3) begin kd = PM; end
      apb_wr(8'h24, 32'(kd)); apb_wr(8'h28, 32'(pl)); apb_wr(8'h2C, 32'(bo));
      apb_wr(8'h1C, 32'(PM)); apb_wr(8'h18, 32'(~m));
      v0 = NP'($urandom()); v1 = NP'($urandom());
      pin_in = v0;
      repeat (4) @(negedge clk);
      apb_rd(8'h20, rd);
      pin_in = v1;
      repeat (4) @(negedge clk);
      ex = (kd & (lvl_hit(v0, pl) | lvl_hit(v1, pl))) | (~kd & edge_hit(v0, v1, pl, bo));
      chk("R9 irq from unmasked status", {31'd0, irq}, {31'd0, |(ex & ~m)});
      apb_rd(8'h20, rd); chk("R6/R7 status", rd, 32'(ex));
      apb_rd(8'h20, rd); chk("R8 re-set after clear", rd, 32'(kd & lvl_hit(v1, pl)));
      repeat (3) @(negedge clk);
      chk("R9 irq after clear", {31'd0, irq}, {31'd0, |(kd & lvl_hit(v1, pl) & ~m)});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule